// File: doc/BRIEF.md
# Non-Volatile Array Program Sequencer with Low-Power Handling

This block runs a single program or erase operation on a small non-volatile array. Software starts an operation through one control register that holds two bits: an arm (latch) bit and a program bit. When both are set, the sequencer turns on a high-voltage enable for a timed phase. The phase lasts a programmable number of clock cycles and is counted by an internal timer. Array reads are refused while the operation is pending.

The core also signals its low-power state. Wait mode leaves the sequencer alone. Stop mode depends on the control bits at the moment stop arrives. With both bits set, the operation pauses: high voltage drops, the timer freezes, and on wake the timed phase starts over from its full length. With the program bit clear, the operation is aborted for good. In both cases a sticky flag reports that the array contents may be damaged. The flag is cleared when the next fresh operation starts.

Top module: `nvm_prog_seq`

## Requirements
- R1: A control write with arm=1 and program=1 starts an operation in the second cycle after the write. `busy_o` and `hv_en_o` then stay high for exactly `op_cycles_i` cycles, or one cycle when `op_cycles_i` is 0. Completion clears both control bits, so no second operation follows without a new write.
- R2: A control write with program=1 and arm=0 stores program as 0 and starts nothing. `busy_o` and `hv_en_o` stay low.
- R3: `wait_i` has no effect. An operation run with `wait_i` high has the same length and high-voltage cycles as one run without it, and reads are still served while idle.
- R4: If `stop_i` rises during an operation while both control bits are set, the sequencer pauses. `hv_en_o` goes low at once, `busy_o` stays high and the timer does not advance.
- R5: After `stop_i` falls, a paused operation restarts its full timed phase. The total count of high-voltage cycles is the count before the pause plus `op_cycles_i`.
- R6: `rd_ack_o` equals `rd_req_i` only while no operation is pending and stop is low. It is 0 whenever `busy_o` is high, including the restart after a pause.
- R7: If `stop_i` rises during an operation while the program bit is clear, the operation aborts. `busy_o` is low from the next cycle and the operation is not resumed after stop ends.
- R8: While `stop_i` is high, `hv_en_o` and `rd_ack_o` are 0. An operation armed while stopped does not start until stop ends.
- R9: `corrupt_o` is set by any pause or abort, survives completion of the restarted phase, and is cleared when a new operation starts.
- R10: `hv_en_o` is high only while an operation is in progress, both control bits are set and stop is low. Clearing the program bit mid-operation drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_latch_i | input | 1 | Arm bit written to the control register |
| ctl_pgm_i | input | 1 | Program bit written to the control register |
| op_cycles_i | input | CNT_W | Length of the timed phase in cycles (0 means 1) |
| wait_i | input | 1 | Core is in wait mode |
| stop_i | input | 1 | Core is in stop mode (has priority over wait) |
| rd_req_i | input | 1 | Array read request from the data port |
| rd_ack_o | output | 1 | Read request served |
| hv_en_o | output | 1 | High-voltage supply enable |
| busy_o | output | 1 | Operation pending (running or paused) |
| corrupt_o | output | 1 | Last operation was interrupted by stop |

## Verification
The bench sweeps the phase length and, for each length, every pause point inside the phase. A design that resumed the frozen count instead of reloading it would give fewer than k+N high-voltage cycles. A design that dropped `busy_o` while paused would release reads too early. A separate case clears the program bit mid-run and then enters stop: an abort that was treated as a pause would bring the operation back after wake. Further cases write the program bit alone, arm an operation while stopped, and run lengths of 0 and 1, which catch off-by-one timer loads and starts that ignore the arm bit.

// File: rtl/nvm_seq_pkg.sv
`timescale 1ns/1ps
package nvm_seq_pkg;
  typedef enum logic [1:0] {MODE_RUN, MODE_WAIT, MODE_STOP} core_mode_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_RUN, SEQ_PAUSE} seq_state_e;
endpackage

// File: rtl/nvm_mode_dec.sv
`timescale 1ns/1ps
module nvm_mode_dec
  import nvm_seq_pkg::*;
(
  input  logic       stop_i,
  input  logic       wait_i,
  output core_mode_e mode_o
);
  // stop dominates wait
  always_comb begin
    if (stop_i)      mode_o = MODE_STOP;
    else if (wait_i) mode_o = MODE_WAIT;
    else             mode_o = MODE_RUN;
  end
endmodule

// File: rtl/nvm_op_timer.sv
`timescale 1ns/1ps
module nvm_op_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             en_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_eff;

  assign len_eff = (len_i == '0) ? ONE : len_i;
  assign done_o  = en_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_eff;
    else if (en_i)   cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/nvm_seq_fsm.sv
`timescale 1ns/1ps
module nvm_seq_fsm
  import nvm_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic       ctl_latch_i,
  input  logic       ctl_pgm_i,
  input  core_mode_e mode_i,
  input  logic       timer_done_i,
  input  logic       rd_req_i,
  output logic       timer_load_o,
  output logic       timer_en_o,
  output logic       hv_en_o,
  output logic       busy_o,
  output logic       corrupt_o,
  output logic       rd_ack_o
);
  seq_state_e state_q, state_d;
  logic latch_q, pgm_q;
  logic bits_clr;
  logic corrupt_set, corrupt_clr;
  logic stopped, armed;

  assign stopped = (mode_i == MODE_STOP);
  assign armed   = latch_q && pgm_q;

  always_comb begin
    state_d      = state_q;
    timer_load_o = 1'b0;
    bits_clr     = 1'b0;
    corrupt_set  = 1'b0;
    corrupt_clr  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (armed && !stopped) begin
          state_d      = SEQ_RUN;
          timer_load_o = 1'b1;
          corrupt_clr  = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (stopped) begin
          corrupt_set = 1'b1;
          if (armed) state_d = SEQ_PAUSE;
          else begin
            state_d  = SEQ_IDLE;   // abort, never resumed
            bits_clr = 1'b1;
          end
        end else if (timer_done_i) begin
          state_d  = SEQ_IDLE;
          bits_clr = 1'b1;
        end
      end
      SEQ_PAUSE: begin
        if (!stopped) begin
          state_d      = SEQ_RUN;
          timer_load_o = 1'b1;     // restart full phase
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      latch_q   <= 1'b0;
      pgm_q     <= 1'b0;
      corrupt_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (bits_clr) begin
        latch_q <= 1'b0;
        pgm_q   <= 1'b0;
      end else if (ctl_we_i) begin
        latch_q <= ctl_latch_i;
        pgm_q   <= ctl_pgm_i && ctl_latch_i;  // program alone is dropped
      end
      if (corrupt_set)      corrupt_o <= 1'b1;
      else if (corrupt_clr) corrupt_o <= 1'b0;
    end
  end

  assign timer_en_o = (state_q == SEQ_RUN) && !stopped;
  assign hv_en_o    = timer_en_o && armed;
  assign busy_o     = (state_q != SEQ_IDLE);
  assign rd_ack_o   = rd_req_i && !busy_o && !stopped;
endmodule

// File: rtl/nvm_prog_seq.sv
`timescale 1ns/1ps
module nvm_prog_seq
  import nvm_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic             ctl_latch_i,
  input  logic             ctl_pgm_i,
  input  logic [CNT_W-1:0] op_cycles_i,
  input  logic             wait_i,
  input  logic             stop_i,
  input  logic             rd_req_i,
  output logic             rd_ack_o,
  output logic             hv_en_o,
  output logic             busy_o,
  output logic             corrupt_o
);
  core_mode_e mode;
  logic       tmr_load, tmr_en, tmr_done;

  nvm_mode_dec i_mode_dec (
    .stop_i (stop_i),
    .wait_i (wait_i),
    .mode_o (mode)
  );

  nvm_op_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (op_cycles_i),
    .en_i   (tmr_en),
    .done_o (tmr_done)
  );

  nvm_seq_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctl_we_i     (ctl_we_i),
    .ctl_latch_i  (ctl_latch_i),
    .ctl_pgm_i    (ctl_pgm_i),
    .mode_i       (mode),
    .timer_done_i (tmr_done),
    .rd_req_i     (rd_req_i),
    .timer_load_o (tmr_load),
    .timer_en_o   (tmr_en),
    .hv_en_o      (hv_en_o),
    .busy_o       (busy_o),
    .corrupt_o    (corrupt_o),
    .rd_ack_o     (rd_ack_o)
  );
endmodule

// File: rtl/nvm_prog_seq_chk.sv
`timescale 1ns/1ps
module nvm_prog_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctl_we_i,
  input logic stop_i,
  input logic rd_ack_o,
  input logic hv_en_o,
  input logic busy_o,
  input logic corrupt_o
);
  AST_HV_OFF_IN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> !stop_i); // R8
  AST_NO_READ_IN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !rd_ack_o); // R8
  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rd_ack_o); // R6
  AST_HV_NEEDS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> busy_o); // R10
  AST_PAUSE_KEEPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i && $past(hv_en_o) && !$past(ctl_we_i)) |=> busy_o); // R4
  AST_PAUSE_MARKS_CORRUPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i) |=> corrupt_o); // R9
  AST_START_CLEARS_CORRUPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !corrupt_o); // R9
endmodule

bind nvm_prog_seq nvm_prog_seq_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctl_we_i  (ctl_we_i),
  .stop_i    (stop_i),
  .rd_ack_o  (rd_ack_o),
  .hv_en_o   (hv_en_o),
  .busy_o    (busy_o),
  .corrupt_o (corrupt_o)
);

// File: tb/test_nvm_prog_seq.sv
`timescale 1ns/1ps
module test_nvm_prog_seq;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, lat = 1'b0, pgm = 1'b0;
  logic [CNT_W-1:0] ncyc = '0;
  logic wt = 1'b0, stp = 1'b0, rreq = 1'b0;
  logic rack, hv, busy, corrupt;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  nvm_prog_seq #(.CNT_W(CNT_W)) i_nvm_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_latch_i(lat), .ctl_pgm_i(pgm),
    .op_cycles_i(ncyc), .wait_i(wt), .stop_i(stp), .rd_req_i(rreq),
    .rd_ack_o(rack), .hv_en_o(hv), .busy_o(busy), .corrupt_o(corrupt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic l, input logic p);
    @(negedge clk); we = 1'b1; lat = l; pgm = p;
    @(negedge clk); we = 1'b0;
  endtask

  // counts samples until busy has been seen and then falls
  task automatic run_out(output int hv_c, output int busy_c, output int rd_bad);
    hv_c = 0; busy_c = 0; rd_bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (busy) busy_c++;
      if (hv) hv_c++;
      if (busy && rack) rd_bad++;
      if (!busy && busy_c > 0) break;
    end
  endtask

  task automatic idle_watch(input int cyc, output int busy_c, output int hv_c);
    busy_c = 0; hv_c = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (busy) busy_c++;
      if (hv) hv_c++;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hc, bc, rb, exp_len;
    rreq = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset busy", int'(busy), 0);
    chk("R10 reset hv", int'(hv), 0);
    chk("R9 reset corrupt", int'(corrupt), 0);
    chk("R6 idle read", int'(rack), 1);

    // R1 / R6: length sweep, lengths 0..12
    for (int n = 0; n <= 12; n++) begin
      ncyc = CNT_W'(n);
      exp_len = (n == 0) ? 1 : n;
      wr(1'b1, 1'b1);
      chk("R1 not started before second cycle", int'(busy), 0);
      run_out(hc, bc, rb);
      chk("R1 hv cycles", hc, exp_len);
      chk("R1 busy cycles", bc, exp_len);
      chk("R6 read blocked while busy", rb, 0);
      chk("R6 read served after done", int'(rack), 1);
      idle_watch(4, bc, hc);
      chk("R1 no restart after done", bc, 0);
    end

    // R3: wait has no effect
    wt = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      ncyc = CNT_W'(n);
      wr(1'b1, 1'b1);
      run_out(hc, bc, rb);
      chk("R3 hv cycles in wait", hc, n);
      chk("R3 busy cycles in wait", bc, n);
      chk("R3 read in wait when idle", int'(rack), 1);
    end
    wt = 1'b0;

    // R2: program bit without arm
    wr(1'b0, 1'b1);
    idle_watch(10, bc, hc);
    chk("R2 no busy on program-only write", bc, 0);
    chk("R2 no hv on program-only write", hc, 0);

    // R4 / R5 / R8 / R9: pause at every point inside the phase
    for (int n = 2; n <= 8; n++) begin
      for (int k = 1; k < n; k++) begin
        int hv_stop, busy_stop, rd_stop;
        ncyc = CNT_W'(n);
        wr(1'b1, 1'b1);
        hc = 0;
        for (int g = 0; g < 40 && hc < k; g++) begin
          @(negedge clk);
          if (hv) hc++;
        end
        stp = 1'b1;
        wt = (k % 2 == 0);   // stop must dominate wait
        hv_stop = 0; busy_stop = 0; rd_stop = 0;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          if (hv) hv_stop++;
          if (busy) busy_stop++;
          if (rack) rd_stop++;
        end
        chk("R4 hv off while paused", hv_stop, 0);
        chk("R4 busy held while paused", busy_stop, 3);
        chk("R8 no read while stopped", rd_stop, 0);
        chk("R9 corrupt after pause", int'(corrupt), 1);
        stp = 1'b0; wt = 1'b0;
        run_out(hc, bc, rb);
        chk("R5 full phase after restart", hc, n);
        chk("R6 read blocked during restart", rb, 0);
        chk("R9 corrupt kept after restart", int'(corrupt), 1);
      end
    end

    // R9: fresh operation clears corrupt
    ncyc = CNT_W'(3);
    wr(1'b1, 1'b1);
    @(negedge clk);
    chk("R9 corrupt cleared on start", int'(corrupt), 0);
    run_out(hc, bc, rb);

    // R7 / R10: abort with program bit cleared (arm kept, then arm cleared)
    for (int v = 0; v < 2; v++) begin
      ncyc = CNT_W'(12);
      wr(1'b1, 1'b1);
      repeat (3) @(negedge clk);
      wr(v == 0, 1'b0);
      chk("R10 hv drops when program cleared", int'(hv), 0);
      chk("R7 still busy before stop", int'(busy), 1);
      stp = 1'b1;
      @(negedge clk);
      chk("R7 busy low after abort", int'(busy), 0);
      chk("R9 corrupt after abort", int'(corrupt), 1);
      repeat (2) @(negedge clk);
      stp = 1'b0;
      idle_watch(20, bc, hc);
      chk("R7 aborted op not resumed busy", bc, 0);
      chk("R7 aborted op not resumed hv", hc, 0);
    end

    // R8: arming while stopped defers the start
    stp = 1'b1;
    ncyc = CNT_W'(4);
    wr(1'b1, 1'b1);
    idle_watch(5, bc, hc);
    chk("R8 no start while stopped", bc, 0);
    chk("R8 idle read blocked in stop", int'(rack), 0);
    stp = 1'b0;
    run_out(hc, bc, rb);
    chk("R8 deferred op runs after stop", hc, 4);
    chk("R9 deferred fresh op clears corrupt", int'(corrupt), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule